// File: doc/BRIEF.md
# Multi-Channel Hit Buffer Readout Controller

This block sits behind a set of per-channel edge encoders. Each clock it can record one word into a 128-entry circular store. A word holds, for every one of four channels, a 6-bit rising-edge code and a 6-bit falling-edge code. In each code, bit 5 is the hit tag and bits 4:0 are the encoded position. A write pointer and a read pointer, both loadable 7-bit up-counters, address the store. A start input for recording and a start input for readout each produce a registered run flag.

Readout has four modes. The two synchronous modes present one word per clock while readout runs. One of them merges hit tags across channels so that a downstream buffer can suppress empty words with a single strobe. The two asynchronous modes are paced by an external read clock, which must be synchronous to `clk`. One of them exposes all channels. The other enables only one selected channel. A strobe marks every presented word. A pulse option narrows the hit tags to that strobe cycle. Output enables are driven as plain outputs rather than as tri-state pads.

Top module: `hbuf_readout_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears both pointers, both run flags, the held output word, `rd_ptr` and `word_strobe`. So after reset the outputs read zero.
- R2: `wr_run` equals `wr_start` and `rd_run` equals `rd_start`, each as sampled on the previous clock edge.
- R3: In each cycle where `wr_run` is high and no write block applies, the store records `{fall_in, rise_in}` at the write pointer. The write pointer then advances by one, and it wraps from 127 to 0. Channel c occupies bits `[6c+5:6c]` of `rise_in` and of `fall_in`, with bit 5 of each field as the hit tag.
- R4: A load input sets its pointer to the load value on the next edge. A load takes priority over any increment in the same cycle.
- R5: With `rd_mode` 0 or 1 and `rd_run` high, the word at the read pointer appears on `rise_out`/`fall_out` one clock later. The pointer value used for the read appears on `rd_ptr` in the same cycle.
- R6: For a word captured in mode 1, three tags are replaced and all other tags are kept. Channel 0's rising tag becomes the OR of the four rising tags. Channel 0's falling tag becomes the OR of the four falling tags. Channel 1's rising tag becomes the OR of all eight tags.
- R7: Unless `rp_sync_off` is high, the read pointer advances by one in every cycle in which a word is written.
- R8: With `rd_mode` 2 or 3, a word is captured on each sampled rising edge of `rd_clk_ext`, and `rd_run` is not needed. When `rp_auto_async` is high, each sampled falling edge advances the read pointer by one.
- R9: With `rd_mode` 2 or 3 and `rd_run` high, no word is written and the write pointer holds. When `rd_run` is low, writing proceeds.
- R10: With `out_en` low, `ch_oe` and `rp_oe` are zero. With `out_en` high, `rp_oe` is one. `ch_oe` is all ones in modes 0 to 2. In mode 3, `ch_oe` has only bit `ch_sel` set.
- R11: With `zs_pulse` high, every hit tag output is zero except in cycles where `word_strobe` is high. With `zs_pulse` low, tags are held like the data bits.
- R12: `word_strobe` is high for exactly the one cycle after each capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_start | input | 1 | Recording request |
| rd_start | input | 1 | Readout request |
| rd_mode | input | 2 | 0 sync per-channel, 1 sync merged tags, 2 async all, 3 async single |
| ch_sel | input | 2 | Channel chosen in mode 3 |
| out_en | input | 1 | Master output enable |
| zs_pulse | input | 1 | Hit tags pulsed on the strobe cycle |
| rd_clk_ext | input | 1 | External read pacing clock (synchronous to clk) |
| rp_sync_off | input | 1 | Stops read-pointer advance with writes |
| rp_auto_async | input | 1 | Read pointer advances on read-clock fall |
| wp_load | input | 1 | Load write pointer |
| wp_load_val | input | 7 | Write pointer load value |
| rp_load | input | 1 | Load read pointer |
| rp_load_val | input | 7 | Read pointer load value |
| rise_in | input | 24 | Rising codes, 6 bits per channel |
| fall_in | input | 24 | Falling codes, 6 bits per channel |
| wr_run | output | 1 | Recording active |
| rd_run | output | 1 | Readout active |
| rise_out | output | 24 | Presented rising codes |
| fall_out | output | 24 | Presented falling codes |
| rd_ptr | output | 7 | Address of the presented word |
| ch_oe | output | 4 | Per-channel output enables |
| rp_oe | output | 1 | Read-pointer output enable |
| word_strobe | output | 1 | One-cycle mark per presented word |

## Verification
The results fall into three timing groups.

The output enables are combinational and settle in the same cycle as `rd_mode`, `ch_sel` and `out_en`. The run flags, `word_strobe`, `rd_ptr` and the presented word all appear one edge after the capture or start condition that produces them. Pointer updates take effect on the next edge, so a loaded or incremented read pointer first shows on `rd_ptr` one further capture later.

The reference model advances its state on each rising edge from the inputs held at that edge. It compares every output at the following falling edge, once all of these delays have elapsed. Stimulus changes 2 ns after a rising edge, so neither side sees a race.

// File: rtl/hbuf_pkg.sv
// Shared definitions for the hit buffer readout controller.
// Assumes: the readout mode is a 2-bit code whose upper bit marks asynchronous pacing.
package hbuf_pkg;
    typedef enum logic [1:0] {
        RM_SYNC_EACH = 2'd0,
        RM_SYNC_OR   = 2'd1,
        RM_ASYNC_ALL = 2'd2,
        RM_ASYNC_ONE = 2'd3
    } rmode_e;
endpackage

// File: rtl/hbuf_ptr.sv
// Loadable wrapping up-counter used for the write and read addresses.
// Assumes: a load outranks an increment in the same cycle.
module hbuf_ptr #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] q
);
    // Purpose: clear, load or step the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= load_val;
        else if (inc)  q <= q + 1'b1;
    end
endmodule

// File: rtl/hbuf_store.sv
// Circular word store with one synchronous write port and one combinational read port.
// Assumes: contents are not reset; a read of the address being written returns the old word.
module hbuf_store #(
    parameter int AW = 7,
    parameter int DW = 48
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    // Purpose: record one word when enabled.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/hbuf_outsel.sv
// Tag merging for the merged-tag mode and output-enable decode per mode.
// Assumes: at least two channels; bit CW-1 of each field is the hit tag.
module hbuf_outsel
    import hbuf_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 6,
    parameter int CSW = 2
) (
    input  logic [1:0]       mode,
    input  logic [CSW-1:0]   ch_sel,
    input  logic             out_en,
    input  logic [NCH*CW-1:0] raw_rise,
    input  logic [NCH*CW-1:0] raw_fall,
    output logic [NCH*CW-1:0] mrg_rise,
    output logic [NCH*CW-1:0] mrg_fall,
    output logic [NCH-1:0]    ch_oe,
    output logic              rp_oe
);
    localparam int TAG = CW - 1;
    logic [NCH-1:0] rtags, ftags;

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_tag
            assign rtags[c] = raw_rise[c*CW+TAG];
            assign ftags[c] = raw_fall[c*CW+TAG];
        end
    endgenerate

    // Purpose: replace three tags with cross-channel ORs in merged mode.
    always_comb begin
        mrg_rise = raw_rise;
        mrg_fall = raw_fall;
        if (rmode_e'(mode) == RM_SYNC_OR) begin
            mrg_rise[TAG]    = |rtags;
            mrg_fall[TAG]    = |ftags;
            mrg_rise[CW+TAG] = (|rtags) | (|ftags);
        end
    end

    // Purpose: choose which channel outputs are enabled.
    always_comb begin
        ch_oe = '0;
        if (out_en) begin
            if (rmode_e'(mode) == RM_ASYNC_ONE) ch_oe[ch_sel] = 1'b1;
            else                                ch_oe = '1;
        end
        rp_oe = out_en;
    end
endmodule

// File: rtl/hbuf_readout_ctrl.sv
// Top of the hit buffer readout controller: run flags, write gating, pointer stepping,
// capture of the presented word and tag strobing.
// Assumes: rd_clk_ext is synchronous to clk; rst_n is synchronous and active low.
module hbuf_readout_ctrl #(
    parameter int NCH = 4,
    parameter int CW  = 6,
    parameter int AW  = 7,
    parameter int CSW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic              rd_start,
    input  logic [1:0]        rd_mode,
    input  logic [CSW-1:0]    ch_sel,
    input  logic              out_en,
    input  logic              zs_pulse,
    input  logic              rd_clk_ext,
    input  logic              rp_sync_off,
    input  logic              rp_auto_async,
    input  logic              wp_load,
    input  logic [AW-1:0]     wp_load_val,
    input  logic              rp_load,
    input  logic [AW-1:0]     rp_load_val,
    input  logic [NCH*CW-1:0] rise_in,
    input  logic [NCH*CW-1:0] fall_in,
    output logic              wr_run,
    output logic              rd_run,
    output logic [NCH*CW-1:0] rise_out,
    output logic [NCH*CW-1:0] fall_out,
    output logic [AW-1:0]     rd_ptr,
    output logic [NCH-1:0]    ch_oe,
    output logic              rp_oe,
    output logic              word_strobe
);
    localparam int SW  = NCH * CW;
    localparam int DW  = 2 * SW;
    localparam int TAG = CW - 1;

    logic          async_m, do_wr, rclk_d, rclk_rise, rclk_fall, cap, rp_inc;
    logic [AW-1:0] wp_q, rp_q;
    logic [DW-1:0] rdata;
    logic [SW-1:0] mrg_rise, mrg_fall, hold_rise, hold_fall;
    logic          tag_gate;
    logic [2*NCH-1:0] tag_vec;

    assign async_m   = rd_mode[1];
    assign do_wr     = wr_run & ~(async_m & rd_run);
    assign rclk_rise = rd_clk_ext & ~rclk_d;
    assign rclk_fall = ~rd_clk_ext & rclk_d;
    assign cap       = async_m ? rclk_rise : rd_run;
    assign rp_inc    = (do_wr & ~rp_sync_off) | (async_m & rp_auto_async & rclk_fall);

    hbuf_ptr #(.AW(AW)) u_wp (
        .clk(clk), .rst_n(rst_n), .load(wp_load), .load_val(wp_load_val),
        .inc(do_wr), .q(wp_q)
    );

    hbuf_ptr #(.AW(AW)) u_rp (
        .clk(clk), .rst_n(rst_n), .load(rp_load), .load_val(rp_load_val),
        .inc(rp_inc), .q(rp_q)
    );

    hbuf_store #(.AW(AW), .DW(DW)) u_store (
        .clk(clk), .we(do_wr), .waddr(wp_q), .wdata({fall_in, rise_in}),
        .raddr(rp_q), .rdata(rdata)
    );

    hbuf_outsel #(.NCH(NCH), .CW(CW), .CSW(CSW)) u_sel (
        .mode(rd_mode), .ch_sel(ch_sel), .out_en(out_en),
        .raw_rise(rdata[SW-1:0]), .raw_fall(rdata[DW-1:SW]),
        .mrg_rise(mrg_rise), .mrg_fall(mrg_fall), .ch_oe(ch_oe), .rp_oe(rp_oe)
    );

    // Purpose: register run flags and the read-clock sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_run <= 1'b0;
            rd_run <= 1'b0;
            rclk_d <= 1'b0;
        end else begin
            wr_run <= wr_start;
            rd_run <= rd_start;
            rclk_d <= rd_clk_ext;
        end
    end

    // Purpose: hold the captured word, its address and the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_rise   <= '0;
            hold_fall   <= '0;
            rd_ptr      <= '0;
            word_strobe <= 1'b0;
        end else begin
            word_strobe <= cap;
            if (cap) begin
                hold_rise <= mrg_rise;
                hold_fall <= mrg_fall;
                rd_ptr    <= rp_q;
            end
        end
    end

    assign tag_gate = ~zs_pulse | word_strobe;

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_out
            assign rise_out[c*CW +: CW] = {hold_rise[c*CW+TAG] & tag_gate, hold_rise[c*CW +: TAG]};
            assign fall_out[c*CW +: CW] = {hold_fall[c*CW+TAG] & tag_gate, hold_fall[c*CW +: TAG]};
            assign tag_vec[c]       = rise_out[c*CW+TAG];
            assign tag_vec[NCH + c] = fall_out[c*CW+TAG];
        end
    endgenerate

    AST_WP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && !wp_load) |=> (wp_q == AW'($past(wp_q) + 1'b1))); // R3
    AST_NO_ASYNC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (async_m && rd_run && !wp_load) |=> $stable(wp_q)); // R9
    AST_TAG_PULSED: assert property (@(posedge clk) disable iff (!rst_n)
        (zs_pulse && !word_strobe) |-> (tag_vec == '0)); // R11
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (word_strobe && async_m && $past(async_m)) |=> !word_strobe); // R12
    AST_RP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rp_load |=> (rp_q == $past(rp_load_val))); // R4
endmodule

// File: tb/tb_hbuf_readout_ctrl.sv
module tb_hbuf_readout_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_start = 0, rd_start = 0, out_en = 0, zs_pulse = 0, rd_clk_ext = 0;
    logic        rp_sync_off = 0, rp_auto_async = 0, wp_load = 0, rp_load = 0;
    logic [1:0]  rd_mode = 0, ch_sel = 0;
    logic [6:0]  wp_load_val = 0, rp_load_val = 0;
    logic [23:0] rise_in = 0, fall_in = 0;
    logic        wr_run, rd_run, rp_oe, word_strobe;
    logic [23:0] rise_out, fall_out;
    logic [6:0]  rd_ptr;
    logic [3:0]  ch_oe;

    int vectors = 0, fails = 0;
    bit done = 0;

    hbuf_readout_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .rd_start(rd_start),
        .rd_mode(rd_mode), .ch_sel(ch_sel), .out_en(out_en), .zs_pulse(zs_pulse),
        .rd_clk_ext(rd_clk_ext), .rp_sync_off(rp_sync_off), .rp_auto_async(rp_auto_async),
        .wp_load(wp_load), .wp_load_val(wp_load_val), .rp_load(rp_load),
        .rp_load_val(rp_load_val), .rise_in(rise_in), .fall_in(fall_in),
        .wr_run(wr_run), .rd_run(rd_run), .rise_out(rise_out), .fall_out(fall_out),
        .rd_ptr(rd_ptr), .ch_oe(ch_oe), .rp_oe(rp_oe), .word_strobe(word_strobe)
    );

    always #4 clk = ~clk;

    // Behavioural reference state
    logic [47:0] mmem [128];
    bit          mval [128];
    bit          m_wr_run, m_rd_run, m_rclk, m_cap, m_ok;
    int          m_wp, m_rp, m_rpq;
    logic [23:0] m_rise, m_fall, t_r, t_f;
    bit          t_do_wr, t_rise, t_fall, t_cap, or_r, or_f;

    initial begin
        for (int i = 0; i < 128; i++) mval[i] = 0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_wr_run = 0; m_rd_run = 0; m_rclk = 0; m_cap = 0; m_ok = 1;
            m_wp = 0; m_rp = 0; m_rpq = 0; m_rise = 0; m_fall = 0;
        end else begin
            t_do_wr = m_wr_run && !(rd_mode[1] && m_rd_run);
            t_rise  = rd_clk_ext && !m_rclk;
            t_fall  = !rd_clk_ext && m_rclk;
            t_cap   = rd_mode[1] ? t_rise : m_rd_run;
            if (t_cap) begin
                {t_f, t_r} = mmem[m_rp];
                if (rd_mode == 2'd1) begin
                    or_r = 0; or_f = 0;
                    for (int c = 0; c < 4; c++) begin
                        or_r = or_r | t_r[c*6+5];
                        or_f = or_f | t_f[c*6+5];
                    end
                    t_r[5] = or_r; t_f[5] = or_f; t_r[11] = or_r | or_f;
                end
                m_rise = t_r; m_fall = t_f; m_ok = mval[m_rp]; m_rpq = m_rp;
            end
            m_cap = t_cap;
            if (t_do_wr) begin
                mmem[m_wp] = {fall_in, rise_in};
                mval[m_wp] = 1;
            end
            if (wp_load) m_wp = int'(wp_load_val);
            else if (t_do_wr) m_wp = (m_wp + 1) % 128;
            if (rp_load) m_rp = int'(rp_load_val);
            else if ((t_do_wr && !rp_sync_off) || (rd_mode[1] && rp_auto_async && t_fall))
                m_rp = (m_rp + 1) % 128;
            m_wr_run = wr_start; m_rd_run = rd_start; m_rclk = rd_clk_ext;
        end
    end

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model away from the active edge
    always @(negedge clk) begin
        logic [23:0] e_r, e_f, tmask;
        logic [3:0]  e_oe;
        bit          gate;
        if (rst_n && !done) begin
            gate = !zs_pulse || m_cap;
            e_r = m_rise; e_f = m_fall; tmask = 0;
            for (int c = 0; c < 4; c++) begin
                e_r[c*6+5] = e_r[c*6+5] & gate;
                e_f[c*6+5] = e_f[c*6+5] & gate;
                tmask[c*6+5] = 1'b1;
            end
            if (m_ok) begin
                check("R3 R4 R5 R6 R9 R11 rise word", 64'(rise_out), 64'(e_r));
                check("R3 R4 R5 R6 R9 R11 fall word", 64'(fall_out), 64'(e_f));
            end else if (!gate) begin
                check("R11 rise tags", 64'(rise_out & tmask), 64'd0);
                check("R11 fall tags", 64'(fall_out & tmask), 64'd0);
            end
            check("R2 wr_run", 64'(wr_run), 64'(m_wr_run));
            check("R2 rd_run", 64'(rd_run), 64'(m_rd_run));
            check("R4 R5 R7 R8 rd_ptr", 64'(rd_ptr), 64'(m_rpq));
            check("R8 R12 word_strobe", 64'(word_strobe), 64'(m_cap));
            e_oe = !out_en ? 4'd0 : (rd_mode == 2'd3 ? 4'(1 << ch_sel) : 4'hF);
            check("R10 ch_oe", 64'(ch_oe), 64'(e_oe));
            check("R10 rp_oe", 64'(rp_oe), 64'(out_en));
        end
    end

    task automatic tick(int n);
        repeat (n) begin
            @(posedge clk); #2;
            rise_in = 24'($urandom);
            fall_in = 24'($urandom);
        end
    endtask

    task automatic rclk_pulses(int n, int hi, int lo);
        repeat (n) begin
            rd_clk_ext = 1; tick(hi);
            rd_clk_ext = 0; tick(lo);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state visible at the ports
        check("R1 rd_ptr", 64'(rd_ptr), 0);
        check("R1 rise_out", 64'(rise_out), 0);
        check("R1 strobe run", 64'({word_strobe, wr_run, rd_run}), 0);
        // R4 loads, then R3 writes wrapping past 127
        @(posedge clk); #2;
        wp_load = 1; wp_load_val = 7'd120; rp_load = 1; rp_load_val = 7'd120;
        tick(1);
        wp_load = 0; rp_load = 0; rp_sync_off = 1; wr_start = 1;
        tick(30);
        wr_start = 0;
        tick(2);
        // R5 synchronous readout across the wrap
        rp_load = 1; rp_load_val = 7'd118;
        tick(1);
        rp_load = 0; rd_start = 1; out_en = 1;
        tick(40);
        zs_pulse = 1; tick(10);            // R11
        rd_mode = 2'd1; tick(20);          // R6
        zs_pulse = 0; tick(10);
        // R7 reading while writing with pointer tied to writes
        rd_mode = 2'd0; rp_sync_off = 0; wr_start = 1;
        tick(20);
        rp_load = 1; rp_load_val = 7'd5; tick(1); rp_load = 0;   // R4 priority
        tick(20);
        // R8 R9 async all-channel, writes blocked while reading
        rd_mode = 2'd2; rp_auto_async = 1;
        rclk_pulses(30, 2, 2);
        rp_auto_async = 0; rclk_pulses(6, 1, 3);
        out_en = 0; rclk_pulses(4, 2, 2); out_en = 1;
        // R10 single-channel mode with each selection
        rd_mode = 2'd3; rp_auto_async = 1;
        for (int s = 0; s < 4; s++) begin
            ch_sel = 2'(s);
            rclk_pulses(5, 1, 1);
        end
        zs_pulse = 1; rclk_pulses(8, 1, 2); zs_pulse = 0;
        // R9 converse: async mode with readout stopped lets writes proceed
        rd_start = 0; rd_mode = 2'd2;
        tick(10);
        wp_load = 1; wp_load_val = 7'd3; tick(1); wp_load = 0;   // R4
        tick(10);
        wr_start = 0; rd_start = 1;
        rp_load = 1; rp_load_val = 7'd0; tick(1); rp_load = 0;
        rclk_pulses(20, 2, 1);
        rd_mode = 2'd1; tick(20);
        tick(3);
        finish_run();
    end
endmodule